// File: doc/BRIEF.md
# Chroma Transient Sharpener

This block steepens color edges in a stream of signed Cb/Cr samples. Each color-difference channel has its own path. A path keeps a sliding window of the last five accepted samples. From the ends and the middle of that window it forms a curvature term. The term is scaled by a selectable right shift and passed through a coring stage, which zeroes any correction smaller than a programmable threshold so that low-level noise is not boosted.

The cored correction is added to the window's middle sample. The sum is saturated to the 8-bit range. It is then clamped between the smallest and largest raw samples currently in the window. The added sharpness can therefore never overshoot or undershoot past the local signal levels, which would otherwise show up as false colors at a transition.

Samples are accepted on cycles where the input valid is high. Each accepted sample produces one output exactly three clock cycles later. That output is the sharpened value of the sample that arrived two accepted samples earlier. The threshold and gain inputs are read as static settings: they are changed only while no sample is in flight.

Top module: `chroma_sharpen`

## Requirements
- R1: While reset is asserted, and right after it is released, `outValid` is 0 and both output samples are 0. Every window position starts at 0.
- R2: `outValid` is high exactly three clock cycles after each cycle in which `inValid` was high, and low otherwise, whatever the gaps between valid inputs.
- R3: Let w0 be the sample accepted with the current valid input, w2 the sample accepted two valid inputs before it, and w4 the one accepted four valid inputs before it. The correction is (2*w2 - w0 - w4), arithmetically shifted right by `gainSel` (0 to 3). The output is w2 plus that correction.
- R4: When the magnitude of the shifted correction is below `coreThr` (unsigned), the correction is zero and the output equals w2. A threshold of 0 disables coring.
- R5: The sum of w2 and the correction is saturated to -128..127 and then clamped to the range between the minimum and the maximum of w0..w4 (raw input samples).
- R6: Cb and Cr are processed identically and independently: the content of one channel never changes the other channel's output.
- R7: A sample presented while `inValid` is low is ignored and does not enter the window.
- R8: A constant input held for five or more valid samples produces that same constant at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies `cbIn` and `crIn` |
| cbIn | input | 8 | Cb sample, signed two's complement |
| crIn | input | 8 | Cr sample, signed two's complement |
| coreThr | input | 8 | Coring threshold, unsigned |
| gainSel | input | 2 | Correction right-shift amount, 0 to 3 |
| outValid | output | 1 | Qualifies `cbOut` and `crOut` |
| cbOut | output | 8 | Sharpened Cb, signed |
| crOut | output | 8 | Sharpened Cr, signed |

## Verification
Each pattern targets a different part of the datapath:
- A held constant shows that the curvature term is zero on flat input.
- Slow and fast ramps into a plateau, run at every gain setting, separate the shift amounts and expose the clamp at both ends of an edge.
- A gentle ramp run against several thresholds shows where coring cuts in.
- Full-scale alternation between -128 and 127 drives the sum past both saturation limits.
- Valid inputs interleaved with idle cycles that carry garbage data test both the output timing and the window gating.
- A long pseudo-random stream, with Cb and Cr patterns deliberately unrelated, catches crosstalk between the channels.

// File: rtl/chroma_sharpen_pkg.sv
`timescale 1ns/1ps
package chroma_sharpen_pkg;

  // Per-cycle enables sent from the control to the datapath
  typedef struct packed {
    logic shift;   // accept a new sample into the window
    logic calc;    // capture correction, center and window bounds
    logic emit;    // register the clamped result
  } sharpStrobe_t;

endpackage

// File: rtl/chroma_sharpen_ctrl.sv
`timescale 1ns/1ps
module chroma_sharpen_ctrl
  import chroma_sharpen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output sharpStrobe_t strb,
  output logic         outValid
);

  logic calcQ;
  logic emitQ;
  logic outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calcQ <= 1'b0;
      emitQ <= 1'b0;
      outQ  <= 1'b0;
    end else begin
      calcQ <= inValid;
      emitQ <= calcQ;
      outQ  <= emitQ;
    end
  end

  assign strb.shift = inValid;
  assign strb.calc  = calcQ;
  assign strb.emit  = emitQ;
  assign outValid   = outQ;

  // R2
  first_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> calcQ);

  // R2
  last_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
    emitQ |=> outValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !emitQ |=> !outValid);

endmodule

// File: rtl/chroma_sharpen_lane.sv
`timescale 1ns/1ps
module chroma_sharpen_lane
  import chroma_sharpen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIN    = 5,
  parameter int THR_W  = 8,
  parameter int GAIN_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sharpStrobe_t             strb,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [THR_W-1:0]         coreThr,
  input  logic [GAIN_W-1:0]        gainSel,
  output logic signed [DATA_W-1:0] sampleOut
);

  localparam int CENTER = WIN / 2;
  localparam int DIFF_W = DATA_W + 2;
  localparam int SUM_W  = DATA_W + 3;
  localparam int CMP_W  = ((DIFF_W > THR_W) ? DIFF_W : THR_W) + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  // Window: index 0 newest, WIN-1 oldest
  logic signed [DATA_W-1:0] win [WIN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else if (strb.shift) begin
      win[0] <= sampleIn;
      for (int i = 1; i < WIN; i++) win[i] <= win[i-1];
    end
  end

  // Curvature, scaling and coring
  logic signed [DIFF_W-1:0] midX, newX, oldX, curv, scaled, cored;
  logic        [DIFF_W-1:0] mag;
  logic                     belowThr;

  assign midX   = DIFF_W'(win[CENTER]);
  assign newX   = DIFF_W'(win[0]);
  assign oldX   = DIFF_W'(win[WIN-1]);
  assign curv   = (midX <<< 1) - newX - oldX;
  assign scaled = curv >>> gainSel;
  assign mag    = scaled[DIFF_W-1] ? -scaled : scaled;
  assign belowThr = CMP_W'(mag) < CMP_W'(coreThr);
  assign cored  = belowThr ? '0 : scaled;

  // Local neighbourhood bounds
  logic signed [DATA_W-1:0] winLo, winHi;
  always_comb begin
    winLo = win[0];
    winHi = win[0];
    for (int i = 1; i < WIN; i++) begin
      if (win[i] < winLo) winLo = win[i];
      if (win[i] > winHi) winHi = win[i];
    end
  end

  // Stage 1 registers
  logic signed [DIFF_W-1:0] corrQ;
  logic signed [DATA_W-1:0] midQ, loQ, hiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrQ <= '0;
      midQ  <= '0;
      loQ   <= '0;
      hiQ   <= '0;
    end else if (strb.calc) begin
      corrQ <= cored;
      midQ  <= win[CENTER];
      loQ   <= winLo;
      hiQ   <= winHi;
    end
  end

  // Stage 2: add, saturate, clamp
  logic signed [SUM_W-1:0]  sum;
  logic signed [DATA_W-1:0] satV, clampV;

  assign sum = SUM_W'(midQ) + SUM_W'(corrQ);

  always_comb begin
    if (sum > SAT_HI)      satV = DATA_W'(SAT_HI);
    else if (sum < SAT_LO) satV = DATA_W'(SAT_LO);
    else                   satV = DATA_W'(sum);
    if (satV < loQ)        clampV = loQ;
    else if (satV > hiQ)   clampV = hiQ;
    else                   clampV = satV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sampleOut <= '0;
    else if (strb.emit) sampleOut <= clampV;
  end

  logic [DIFF_W-1:0] corrMag;
  assign corrMag = corrQ[DIFF_W-1] ? -corrQ : corrQ;

  // R4
  coring_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.calc |=> (corrQ == '0 || CMP_W'(corrMag) >= CMP_W'($past(coreThr))));

  // R5
  bounded_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> (sampleOut >= $past(loQ) && sampleOut <= $past(hiQ)));

  // R7
  window_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> ($stable(win[0]) && $stable(win[WIN-1])));

endmodule

// File: rtl/chroma_sharpen_dp.sv
`timescale 1ns/1ps
module chroma_sharpen_dp
  import chroma_sharpen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIN    = 5,
  parameter int THR_W  = 8,
  parameter int GAIN_W = 2,
  parameter int LANES  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sharpStrobe_t                  strb,
  input  logic [LANES-1:0][DATA_W-1:0]  lanesIn,
  input  logic [THR_W-1:0]              coreThr,
  input  logic [GAIN_W-1:0]             gainSel,
  output logic [LANES-1:0][DATA_W-1:0]  lanesOut
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [DATA_W-1:0] laneOut;
    chroma_sharpen_lane #(
      .DATA_W(DATA_W), .WIN(WIN), .THR_W(THR_W), .GAIN_W(GAIN_W)
    ) uLane (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strb),
      .sampleIn  ($signed(lanesIn[g])),
      .coreThr   (coreThr),
      .gainSel   (gainSel),
      .sampleOut (laneOut)
    );
    assign lanesOut[g] = laneOut;
  end

endmodule

// File: rtl/chroma_sharpen.sv
`timescale 1ns/1ps
module chroma_sharpen
  import chroma_sharpen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIN    = 5,
  parameter int THR_W  = 8,
  parameter int GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] cbIn,
  input  logic [DATA_W-1:0] crIn,
  input  logic [THR_W-1:0]  coreThr,
  input  logic [GAIN_W-1:0] gainSel,
  output logic              outValid,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] crOut
);

  localparam int LANES = 2;

  sharpStrobe_t                 strb;
  logic [LANES-1:0][DATA_W-1:0] lanesIn;
  logic [LANES-1:0][DATA_W-1:0] lanesOut;

  assign lanesIn[0] = cbIn;
  assign lanesIn[1] = crIn;

  chroma_sharpen_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  chroma_sharpen_dp #(
    .DATA_W(DATA_W), .WIN(WIN), .THR_W(THR_W), .GAIN_W(GAIN_W), .LANES(LANES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lanesIn  (lanesIn),
    .coreThr  (coreThr),
    .gainSel  (gainSel),
    .lanesOut (lanesOut)
  );

  assign cbOut = lanesOut[0];
  assign crOut = lanesOut[1];

endmodule

// File: tb/chroma_sharpen_test.sv
`timescale 1ns/1ps
module chroma_sharpen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] cbIn = '0;
  logic [7:0] crIn = '0;
  logic [7:0] coreThr = '0;
  logic [1:0] gainSel = '0;
  logic       outValid;
  logic [7:0] cbOut, crOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  chroma_sharpen uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cbIn(cbIn), .crIn(crIn),
    .coreThr(coreThr), .gainSel(gainSel),
    .outValid(outValid), .cbOut(cbOut), .crOut(crOut)
  );

  // Bench-side model state: index 0 newest
  int wCb [5];
  int wCr [5];
  bit    pV   [3];
  int    pCb  [3];
  int    pCr  [3];
  string pTag [3];

  function automatic int model(int n0, int n1, int n2, int n3, int n4,
                               int thr, int gain);
    int d, c, s, lo, hi;
    d = 2 * n2 - n0 - n4;
    c = d >>> gain;
    if ((c < 0 ? -c : c) < thr) c = 0;
    s = n2 + c;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    lo = n0; hi = n0;
    if (n1 < lo) lo = n1;
    if (n2 < lo) lo = n2;
    if (n3 < lo) lo = n3;
    if (n4 < lo) lo = n4;
    if (n1 > hi) hi = n1;
    if (n2 > hi) hi = n2;
    if (n3 > hi) hi = n3;
    if (n4 > hi) hi = n4;
    if (s < lo) s = lo;
    if (s > hi) s = hi;
    return s;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: compare the result due now, then present the next input
  task automatic step(bit v, int cb, int cr, string tag);
    @(negedge clk);
    check(outValid === pV[2], "R2", "outValid", int'(outValid), int'(pV[2]));
    if (pV[2]) begin
      check($signed(cbOut) == pCb[2], pTag[2], "cbOut", $signed(cbOut), pCb[2]);
      check($signed(crOut) == pCr[2], pTag[2], "crOut", $signed(crOut), pCr[2]);
    end
    for (int i = 2; i > 0; i--) begin
      pV[i] = pV[i-1]; pCb[i] = pCb[i-1]; pCr[i] = pCr[i-1]; pTag[i] = pTag[i-1];
    end
    pV[0] = v; pTag[0] = tag;
    if (v) begin
      for (int i = 4; i > 0; i--) begin
        wCb[i] = wCb[i-1]; wCr[i] = wCr[i-1];
      end
      wCb[0] = cb; wCr[0] = cr;
      pCb[0] = model(wCb[0], wCb[1], wCb[2], wCb[3], wCb[4], int'(coreThr), int'(gainSel));
      pCr[0] = model(wCr[0], wCr[1], wCr[2], wCr[3], wCr[4], int'(coreThr), int'(gainSel));
    end
    inValid = v;
    cbIn = cb[7:0];
    crIn = cr[7:0];
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, "R2");
  endtask

  task automatic setCfg(int thr, int gain);
    flush();
    coreThr = thr[7:0];
    gainSel = gain[1:0];
  endtask

  // R1: reset state
  task automatic testReset();
    for (int i = 0; i < 5; i++) begin wCb[i] = 0; wCr[i] = 0; end
    for (int i = 0; i < 3; i++) begin pV[i] = 0; pCb[i] = 0; pCr[i] = 0; pTag[i] = "R2"; end
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(cbOut === 8'd0 && crOut === 8'd0, "R1", "outputs in reset",
          int'(cbOut) | int'(crOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", "outValid after release", int'(outValid), 0);
  endtask

  // R8: constant input passes unchanged once the window is full
  task automatic testFlat();
    setCfg(0, 0);
    for (int i = 0; i < 10; i++) step(1'b1, 40, -30, "R8");
    flush();
    check($signed(cbOut) == 40 && $signed(crOut) == -30, "R8", "flat held",
          $signed(cbOut), 40);
  endtask

  // R3, R5: ramps into plateaus at every gain
  task automatic testEdges();
    int seq [12] = '{0, 0, 0, 10, 20, 60, 100, 100, 100, 70, 5, 0};
    for (int g = 0; g < 4; g++) begin
      setCfg(0, g);
      for (int i = 0; i < 12; i++) step(1'b1, seq[i], -seq[i], "R3");
      for (int i = 0; i < 12; i++) step(1'b1, seq[11-i] / 2, seq[i] - 50, "R5");
    end
  endtask

  // R4: coring thresholds on a gentle ramp
  task automatic testCoring();
    int thrs [4] = '{0, 8, 30, 200};
    for (int t = 0; t < 4; t++) begin
      setCfg(thrs[t], 0);
      for (int i = 0; i < 10; i++) step(1'b1, i * i, 3 * i - 20, "R4");
      for (int i = 0; i < 6; i++) step(1'b1, 81, -2, "R4");
    end
  endtask

  // R5: full-scale alternation, saturation then clamp
  task automatic testExtremes();
    setCfg(0, 0);
    for (int i = 0; i < 12; i++)
      step(1'b1, (i % 2) ? 127 : -128, (i % 3 == 0) ? -128 : 127, "R5");
  endtask

  // R2, R7: gaps with garbage data on idle cycles
  task automatic testGaps();
    setCfg(0, 1);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, i * 9 - 60, 50 - i * 7, "R7");
      for (int k = 0; k < (i % 3); k++) step(1'b0, 127, -128, "R7");
    end
  endtask

  // R6: unrelated channel content, pseudo-random stream
  task automatic testRandom();
    logic [15:0] lfsr = 16'hACE1;
    for (int r = 0; r < 4; r++) begin
      setCfg(r * 6, r);
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[5], $signed(lfsr[15:8]), (i % 8 < 4) ? 90 : -90, "R6");
      end
    end
    flush();
  endtask

  initial begin
    testReset();
    testFlat();
    testEdges();
    testCoring();
    testExtremes();
    testGaps();
    testRandom();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule